// File: doc/BRIEF.md
# Receive Pair Polarity Detector and Corrector

This block watches the receive side of a twisted-pair link and decides whether the pair has been wired with its two conductors swapped. It gets two kinds of evidence. A strobe marks each received link pulse, and a second bit says whether that pulse was seen inverted. Another strobe marks each end of frame, with a bit giving the line polarity sampled after that end of frame. The pair is declared swapped only when both kinds of evidence agree.

Once the pair is declared swapped, the block inverts the serial receive bit stream, unless a disable input forbids correction. The block marks output data as invalid while correction is coming into effect, so that bits from that window can be dropped. The status output and the disable input are independent of each other: with correction disabled, the status still reports a swapped pair.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset, `pol_ok` is 1, `rx_out_valid` is 0 and `rx_out` is 0.
- R2: A link pulse strobe with `lp_reversed`=1 sets a sticky flag. If that flag is set and a run of 4 consecutive end-of-frame strobes with `eof_negative`=1 completes, `pol_ok` reads 0 from the clock edge that samples the completing strobe.
- R3: The order of the evidence does not matter. Four negative frames alone keep `pol_ok` at 1. A reversed link pulse that arrives after such a run declares the reversal at the edge that samples that pulse.
- R4: An end-of-frame strobe with `eof_negative`=0 resets the run of negative frames to zero.
- R5: A link pulse strobe with `lp_reversed`=0 does not count as evidence.
- R6: Once declared, the reversal holds until reset. Positive frames and normal link pulses do not restore `pol_ok`.
- R7: With `corr_dis`=0 and a reversal declared, `rx_out` equals the inverse of `rx_bit` one clock later. `rx_out_valid` equals `rx_bit_en` one clock later, in the same cycle as the data.
- R8: With `corr_dis`=1, `rx_out` is `rx_bit` uninverted and no data is dropped, while `pol_ok` still shows 0 after a declaration.
- R9: With `corr_dis`=0, bits whose `rx_bit_en` falls in the cycle of the declaring strobe, or in any cycle up to and including the next end-of-frame strobe, leave `rx_out_valid` at 0.
- R10: Before any declaration, `rx_out` is `rx_bit` delayed one clock, and `rx_out_valid` is `rx_bit_en` delayed one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_seen | input | 1 | One-cycle strobe: a link pulse was received |
| lp_reversed | input | 1 | With `lp_seen`: the pulse was inverted |
| eof_strobe | input | 1 | One-cycle strobe: a frame ended |
| eof_negative | input | 1 | With `eof_strobe`: the post-frame polarity was negative |
| rx_bit | input | 1 | Serial receive data bit |
| rx_bit_en | input | 1 | `rx_bit` carries a bit this cycle |
| corr_dis | input | 1 | 1 forbids inversion of the data |
| pol_ok | output | 1 | 1 while polarity is taken as correct |
| rx_out | output | 1 | Receive bit after any correction |
| rx_out_valid | output | 1 | `rx_out` carries a bit to keep |

## Verification
Each piece of internal state shows up at the ports within one clock. A lost sticky pulse flag, or a miscounted run of negative frames, shows as `pol_ok` falling one edge early or late, or never falling, in the cycle right after the strobe that should complete the evidence. A wrong inversion state corrupts `rx_out` on the first bit sampled after the declaration. A drop window that is opened or closed wrongly shows as `rx_out_valid` being wrong for the declaring cycle, for the bits before the next end of frame, or for the first bit after that end of frame.

// File: rtl/rxpol_pkg.sv
// Package: shared constants and types for the receive polarity block.
// Assumes: nothing beyond standard SystemVerilog.
package rxpol_pkg;
    // Default length of the run of negative frames needed for a declaration.
    localparam int unsigned RXPOL_NEG_FRAMES = 4;

    // Outputs of the decision stage that steer the data path.
    typedef struct packed {
        logic reversed;   // reversal declared (registered)
        logic invert;     // apply inversion to data this cycle
        logic drop;       // discard data sampled this cycle
    } rxpol_ctrl_t;
endpackage

// File: rtl/rxpol_pulse_flag.sv
// Module: sticky flag for reversed link pulses.
// Assumes: lp_seen is a one-cycle strobe, and lp_reversed is meaningful only with it.
// The flag is cleared when a reversal is declared.
module rxpol_pulse_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_seen,
    input  logic lp_reversed,
    input  logic clear,
    output logic hit
);
    logic flag_q;
    logic rev_pulse;

    // Reversed pulse occurring this cycle.
    assign rev_pulse = lp_seen & lp_reversed;
    // Evidence is present if it was stored earlier or arrives now.
    assign hit = flag_q | rev_pulse;

    // Hold the flag until cleared by a declaration or by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (clear)
            flag_q <= 1'b0;
        else if (rev_pulse)
            flag_q <= 1'b1;
    end
endmodule

// File: rtl/rxpol_frame_run.sv
// Module: counts consecutive frames ending with negative polarity.
// Assumes: eof_strobe is a one-cycle strobe, and eof_negative is qualified by it.
// The count saturates at NEG_FRAMES, and a positive frame resets it to zero.
module rxpol_frame_run #(
    parameter int unsigned NEG_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eof_strobe,
    input  logic eof_negative,
    output logic run_met
);
    localparam int unsigned CNT_W = $clog2(NEG_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NEG_FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: saturating increment on a negative frame, zero on a positive one.
    always_comb begin
        cnt_d = cnt_q;
        if (eof_strobe) begin
            if (!eof_negative)
                cnt_d = '0;
            else if (cnt_q != CNT_MAX)
                cnt_d = cnt_q + 1'b1;
        end
    end

    // The run is complete once the next count reaches the limit.
    assign run_met = (cnt_d == CNT_MAX);

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rxpol_decision.sv
// Module: declares the reversal and manages the window of data to drop.
// Assumes: pulse_hit and run_met are combinational views of the current evidence.
// Once set, the declaration holds until reset. The drop window opens on a
// declaration made with correction enabled, and closes after the next end of frame.
module rxpol_decision
    import rxpol_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pulse_hit,
    input  logic        run_met,
    input  logic        eof_strobe,
    input  logic        corr_dis,
    output logic        declare_now,
    output rxpol_ctrl_t ctrl
);
    logic reversed_q;
    logic drop_q;
    logic open_window;

    // Both kinds of evidence are present, and no reversal is declared yet.
    assign declare_now = ~reversed_q & pulse_hit & run_met;
    assign open_window = declare_now & ~corr_dis;

    // Sticky declaration state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reversed_q <= 1'b0;
        else if (declare_now)
            reversed_q <= 1'b1;
    end

    // Drop window: opening has priority over closing on the same end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= 1'b0;
        else if (open_window)
            drop_q <= 1'b1;
        else if (eof_strobe)
            drop_q <= 1'b0;
    end

    // Control bundle for the data path.
    always_comb begin
        ctrl.reversed = reversed_q;
        ctrl.invert   = reversed_q & ~corr_dis;
        ctrl.drop     = drop_q | open_window;
    end
endmodule

// File: rtl/rxpol_datapath.sv
// Module: a single register stage that inverts the data as needed and qualifies it.
// Assumes: ctrl is valid in the same cycle as rx_bit.
module rxpol_datapath
    import rxpol_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_bit,
    input  logic        rx_bit_en,
    input  rxpol_ctrl_t ctrl,
    output logic        rx_out,
    output logic        rx_out_valid
);
    // Register the corrected bit together with its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_out       <= 1'b0;
            rx_out_valid <= 1'b0;
        end else begin
            rx_out       <= rx_bit ^ ctrl.invert;
            rx_out_valid <= rx_bit_en & ~ctrl.drop;
        end
    end
endmodule

// File: rtl/rx_polarity_fix.sv
// Module: top of the receive polarity detector and corrector.
// Assumes: strobes last one cycle and are synchronous to clk.
// pol_ok is driven from registered state.
module rx_polarity_fix #(
    parameter int unsigned NEG_FRAMES = rxpol_pkg::RXPOL_NEG_FRAMES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_seen,
    input  logic lp_reversed,
    input  logic eof_strobe,
    input  logic eof_negative,
    input  logic rx_bit,
    input  logic rx_bit_en,
    input  logic corr_dis,
    output logic pol_ok,
    output logic rx_out,
    output logic rx_out_valid
);
    import rxpol_pkg::*;

    logic        pulse_hit;
    logic        run_met;
    logic        declare_now;
    rxpol_ctrl_t ctrl;

    rxpol_pulse_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_seen    (lp_seen),
        .lp_reversed(lp_reversed),
        .clear      (declare_now),
        .hit        (pulse_hit)
    );

    rxpol_frame_run #(.NEG_FRAMES(NEG_FRAMES)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .eof_strobe  (eof_strobe),
        .eof_negative(eof_negative),
        .run_met     (run_met)
    );

    rxpol_decision u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_hit  (pulse_hit),
        .run_met    (run_met),
        .eof_strobe (eof_strobe),
        .corr_dis   (corr_dis),
        .declare_now(declare_now),
        .ctrl       (ctrl)
    );

    rxpol_datapath u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .rx_bit_en   (rx_bit_en),
        .ctrl        (ctrl),
        .rx_out      (rx_out),
        .rx_out_valid(rx_out_valid)
    );

    // Status is the inverse of the declaration.
    assign pol_ok = ~ctrl.reversed;
endmodule

// File: rtl/rxpol_checker.sv
// Module: assertion checker bound to rx_polarity_fix; it observes the ports only.
module rxpol_checker (
    input logic clk,
    input logic rst_n,
    input logic lp_seen,
    input logic eof_strobe,
    input logic rx_bit,
    input logic rx_bit_en,
    input logic corr_dis,
    input logic pol_ok,
    input logic rx_out,
    input logic rx_out_valid
);
    // R6: a declared reversal never clears without a reset.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_ok |=> !pol_ok);

    // R2: a declaration follows only a sampled strobe.
    p_fall_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pol_ok) |-> $past(eof_strobe || lp_seen));

    // R7: the valid flag is never produced without an input bit.
    p_valid_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> $past(rx_bit_en));

    // R8: with correction disabled, data passes uninverted.
    p_no_invert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(corr_dis) |-> (rx_out == $past(rx_bit)));

    // R10: with polarity correct, data passes uninverted.
    p_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pol_ok) |-> (rx_out == $past(rx_bit)));

    // R9: the cycle that declares with correction enabled yields no valid data.
    p_drop_decl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pol_ok) && !$past(corr_dis)) |-> !rx_out_valid);
endmodule

bind rx_polarity_fix rxpol_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_seen     (lp_seen),
    .eof_strobe  (eof_strobe),
    .rx_bit      (rx_bit),
    .rx_bit_en   (rx_bit_en),
    .corr_dis    (corr_dis),
    .pol_ok      (pol_ok),
    .rx_out      (rx_out),
    .rx_out_valid(rx_out_valid)
);

// File: tb/rx_polarity_fix_tb.sv
module rx_polarity_fix_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_seen = 1'b0, lp_reversed = 1'b0;
    logic eof_strobe = 1'b0, eof_negative = 1'b0;
    logic rx_bit = 1'b0, rx_bit_en = 1'b0, corr_dis = 1'b0;
    logic pol_ok, rx_out, rx_out_valid;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_polarity_fix u_dut (
        .clk(clk), .rst_n(rst_n), .lp_seen(lp_seen), .lp_reversed(lp_reversed),
        .eof_strobe(eof_strobe), .eof_negative(eof_negative), .rx_bit(rx_bit),
        .rx_bit_en(rx_bit_en), .corr_dis(corr_dis), .pol_ok(pol_ok),
        .rx_out(rx_out), .rx_out_valid(rx_out_valid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the edge.
    task automatic step(input logic lps, input logic lpr, input logic eofs,
                        input logic eofn, input logic b, input logic en);
        lp_seen = lps; lp_reversed = lpr; eof_strobe = eofs;
        eof_negative = eofn; rx_bit = b; rx_bit_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        idle();
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_reset();
        corr_dis = 1'b0;
        do_reset();
        check("R1 pol_ok", pol_ok, 1'b1);
        check("R1 valid", rx_out_valid, 1'b0);
        check("R1 data", rx_out, 1'b0);
    endtask

    task automatic t_plain_data();
        do_reset();
        step(0, 0, 0, 0, 1, 1);
        check("R10 data1", rx_out, 1'b1);
        check("R10 valid1", rx_out_valid, 1'b1);
        step(0, 0, 0, 0, 0, 1);
        check("R10 data0", rx_out, 1'b0);
        step(0, 0, 0, 0, 1, 0);
        check("R10 idle valid", rx_out_valid, 1'b0);
    endtask

    task automatic t_basic_declare();
        do_reset();
        step(1, 1, 0, 0, 0, 0);
        check("R2 after pulse", pol_ok, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1, 1, 0, 0);
            check("R2 partial run", pol_ok, 1'b1);
        end
        step(0, 0, 1, 1, 0, 0);
        check("R2 declared", pol_ok, 1'b0);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 1, 1, 0, 0);
            check("R3 frames only", pol_ok, 1'b1);
        end
        step(1, 0, 0, 0, 0, 0);
        check("R5 normal pulse", pol_ok, 1'b1);
        step(1, 1, 0, 0, 0, 0);
        check("R3 late pulse", pol_ok, 1'b0);
    endtask

    task automatic t_run_reset();
        do_reset();
        step(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        check("R4 positive frame", pol_ok, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1, 1, 0, 0);
            check("R4 restart run", pol_ok, 1'b1);
        end
        step(0, 0, 1, 1, 0, 0);
        check("R4 full run", pol_ok, 1'b0);
    endtask

    task automatic t_sticky();
        step(0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0);
        check("R6 sticky", pol_ok, 1'b0);
    endtask

    task automatic t_correct();
        corr_dis = 1'b0;
        do_reset();
        step(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 1, 1);
        check("R9 declare cycle valid", rx_out_valid, 1'b0);
        step(0, 0, 0, 0, 1, 1);
        check("R9 window valid", rx_out_valid, 1'b0);
        step(0, 0, 1, 1, 0, 1);
        check("R9 closing eof valid", rx_out_valid, 1'b0);
        step(0, 0, 0, 0, 1, 1);
        check("R7 valid", rx_out_valid, 1'b1);
        check("R7 inverted 1", rx_out, 1'b0);
        step(0, 0, 0, 0, 0, 1);
        check("R7 inverted 0", rx_out, 1'b1);
        check("R7 valid aligned", rx_out_valid, 1'b1);
    endtask

    task automatic t_disable();
        corr_dis = 1'b1;
        do_reset();
        step(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 1, 1);
        check("R8 no drop", rx_out_valid, 1'b1);
        check("R8 status", pol_ok, 1'b0);
        step(0, 0, 0, 0, 1, 1);
        check("R8 no invert", rx_out, 1'b1);
        check("R8 valid", rx_out_valid, 1'b1);
        corr_dis = 1'b0;
    endtask

    initial begin
        t_reset();
        t_plain_data();
        t_basic_declare();
        t_sticky();
        t_order();
        t_run_reset();
        t_correct();
        t_disable();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule